// File: doc/BRIEF.md
# Grouped Change-of-State Input Controller

This block watches 48 input-only digital lines, arranged as six groups of eight, and interrupts a host when any line in a watched group changes level. A host on an 8-bit byte bus, with a 3-bit offset and separate read and write strobes, reads each group's present level as one byte. It uses a single control/status byte to choose which groups are watched and to learn which groups changed.

Every line passes through a two-flop synchroniser. A group's edge detector compares the current synchronised sample with the previous one, so both rising and falling edges count. A change in an enabled group sets that group's latched change bit. The interrupt output stays high while any change bit is set. Reading the status byte returns the latched bits and clears them. Writing a zero to a group's enable bit discards that group's pending change. After reset nothing is enabled, so the block stays quiet until software writes the mask.

Top module: `cos_input_ctrl`

## Requirements
- R1: After reset the interrupt output is low, all group enables are cleared, and a status read returns 0x40.
- R2: A read at offset 0, 1, 2, 4, 5 or 6 returns the synchronised levels of group 0, 1, 2, 3, 4 or 5 respectively. Line g*8+b of the 48-bit input appears at data bit b of group g's byte.
- R3: A read at offset 3 returns 0x00.
- R4: Writes to offsets 0 to 6 change neither the input values read back nor the enable mask.
- R5: A write to offset 7 loads the enable mask, where bit n (n = 0..5) enables group n. Data bits 6 and 7 of that write are ignored.
- R6: A rising or a falling level change on any line of an enabled group sets that group's change bit. The interrupt output rises at the third rising clock edge after the input changes (two synchroniser flops, then the latch). A change in a disabled group sets nothing.
- R7: A read at offset 7 returns the latched change bits in bits 0 to 5 and an active-low pending flag in bit 6, which is 0 when any change bit is set. Bit 7 reads 0.
- R8: A read at offset 7 clears every latched change bit, and with them the interrupt, unless a new edge in an enabled group arrives in the same cycle as the read. That edge stays latched.
- R9: The interrupt output is high exactly while some change bit is latched. Writing 0 to a group's enable bit clears that group's change bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lines_in | input | 48 | Asynchronous digital input lines |
| bus_addr | input | 3 | Byte offset within the 8-byte window |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, registered on the read strobe and held until the next read |
| irq | output | 1 | Level interrupt, high while a change is latched |

## Verification
Two functions can meet in the same clock edge: the clear caused by a status read, and the setting of a change bit by a freshly synchronised edge. The bench toggles an enabled line and counts the edges so that the edge detector is active in exactly the cycle the status read strobe is sampled. It then expects the read to return the earlier latched bits, the interrupt to stay high, and a second read to still report the group. A similar collision between an enable write that drops a group and that group's pending bit is judged by the interrupt falling on the following cycle.

// File: rtl/cos_pkg.sv
package cos_pkg;

    localparam int GRP_W    = 8;
    localparam int N_GRP    = 6;
    localparam int N_LINES  = N_GRP * GRP_W;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;
    localparam int PEND_BIT = 6;

    localparam logic [ADDR_W-1:0] CTRL_OFS = 3'd7;
    localparam logic [ADDR_W-1:0] HOLE_OFS = 3'd3;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_PORT,
        SEL_CTRL
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e   kind;
        logic [2:0]  grp;
    } sel_t;

    // Maps a window offset to an access kind and input group index.
    function automatic sel_t decode_ofs(input logic [ADDR_W-1:0] ofs);
        sel_t s;
        s.kind = SEL_PORT;
        s.grp  = 3'd0;
        if (ofs == CTRL_OFS) begin
            s.kind = SEL_CTRL;
        end else if (ofs == HOLE_OFS) begin
            s.kind = SEL_NONE;
        end else if (ofs < HOLE_OFS) begin
            s.grp = ofs;
        end else begin
            s.grp = ofs - 3'd1;
        end
        return s;
    endfunction

endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/cos_group_det.sv
module cos_group_det #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [GW-1:0] smp,
    input  logic          en,
    input  logic          drop,
    input  logic          rd_clr,
    output logic          edge_o,
    output logic          chg
);

    logic [GW-1:0] prev;

    assign edge_o = |(smp ^ prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            chg  <= 1'b0;
        end else begin
            prev <= smp;
            if (drop) begin
                chg <= 1'b0;
            end else if (edge_o && en) begin
                chg <= 1'b1;
            end else if (rd_clr) begin
                chg <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cos_bus_port.sv
module cos_bus_port
    import cos_pkg::*;
#(
    parameter int NG = N_GRP,
    parameter int GW = GRP_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd,
    input  logic                 wr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NG*GW-1:0]     smp,
    input  logic [NG-1:0]        chg,
    output logic [NG-1:0]        en_q,
    output logic [NG-1:0]        drop,
    output logic                 rd_clr,
    output logic [DATA_W-1:0]    rdata
);

    sel_t              sel;
    logic              wr_ctrl;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] rd_val;
    logic              unused_wbits;

    assign sel          = decode_ofs(addr);
    assign wr_ctrl      = wr && (sel.kind == SEL_CTRL);
    assign rd_clr       = rd && (sel.kind == SEL_CTRL);
    assign drop         = wr_ctrl ? ~wdata[NG-1:0] : '0;
    assign unused_wbits = ^wdata[DATA_W-1:NG];

    always_comb begin
        status           = '0;
        status[NG-1:0]   = chg;
        status[PEND_BIT] = ~|chg;
    end

    always_comb begin
        case (sel.kind)
            SEL_CTRL: rd_val = status;
            SEL_PORT: rd_val = smp[int'(sel.grp)*GW +: GW];
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            rdata <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q <= wdata[NG-1:0];
            end
            if (rd) begin
                rdata <= rd_val;
            end
        end
    end

endmodule

// File: rtl/cos_input_ctrl.sv
module cos_input_ctrl
    import cos_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_LINES-1:0]   lines_in,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq
);

    logic [N_LINES-1:0] smp;
    logic [N_GRP-1:0]   en_q;
    logic [N_GRP-1:0]   drop;
    logic [N_GRP-1:0]   chg;
    logic [N_GRP-1:0]   edge_g;
    logic               rd_clr;
    logic               edge_any;

    cos_sync #(.WIDTH(N_LINES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (lines_in),
        .q   (smp)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        cos_group_det #(.GW(GRP_W)) u_det (
            .clk    (clk),
            .rst    (rst),
            .smp    (smp[g*GRP_W +: GRP_W]),
            .en     (en_q[g]),
            .drop   (drop[g]),
            .rd_clr (rd_clr),
            .edge_o (edge_g[g]),
            .chg    (chg[g])
        );
    end

    cos_bus_port #(.NG(N_GRP), .GW(GRP_W)) u_bus (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .wdata  (bus_wdata),
        .smp    (smp),
        .chg    (chg),
        .en_q   (en_q),
        .drop   (drop),
        .rd_clr (rd_clr),
        .rdata  (bus_rdata)
    );

    assign edge_any = |(edge_g & en_q);
    assign irq      = |chg;

endmodule

// File: rtl/cos_input_ctrl_chk.sv
module cos_input_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] bus_addr,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       irq,
    input logic       edge_any
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !irq);

    // R3
    hole_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd3) |=> bus_rdata == 8'h00);

    // R7
    pend_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd7) |=> (bus_rdata[6] == !$past(irq)) && !bus_rdata[7]);

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd7 && !edge_any) |=> !irq);

    // R9
    drop_all_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd7 && bus_wdata[5:0] == 6'd0) |=> !irq);

    // R6
    rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(edge_any));

endmodule

bind cos_input_ctrl cos_input_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .edge_any  (edge_any)
);

// File: tb/cos_input_ctrl_test.sv
`timescale 1ns/1ps
module cos_input_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [47:0] lines_in = '0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cos_input_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .lines_in  (lines_in),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct packed {
        logic [47:0] din;
        logic [2:0]  ofs;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{48'h665544332211, 3'd0, 8'h11},
        '{48'h665544332211, 3'd1, 8'h22},
        '{48'h665544332211, 3'd2, 8'h33},
        '{48'h665544332211, 3'd3, 8'h00},
        '{48'h665544332211, 3'd4, 8'h44},
        '{48'h665544332211, 3'd5, 8'h55},
        '{48'h665544332211, 3'd6, 8'h66},
        '{48'hA5F00F8001FF, 3'd0, 8'hFF},
        '{48'hA5F00F8001FF, 3'd6, 8'hA5},
        '{48'hA5F00F8001FF, 3'd3, 8'h00}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [2:0] ofs, output logic [7:0] val);
        bus_addr = ofs;
        bus_rd   = 1'b1;
        tick();
        bus_rd   = 1'b0;
        val      = bus_rdata;
    endtask

    task automatic bus_write(input logic [2:0] ofs, input logic [7:0] val);
        bus_addr  = ofs;
        bus_wdata = val;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic settle();
        repeat (4) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
        bus_read(3'd7, v);
        check("R1 status after reset", v, 8'h40);

        // R2 R3: vector table of port reads
        for (int i = 0; i < NV; i++) begin
            lines_in = VECS[i].din;
            settle();
            bus_read(VECS[i].ofs, v);
            check(VECS[i].ofs == 3'd3 ? "R3 hole offset" : "R2 port read", v, VECS[i].exp);
        end
        check("R1 no irq while disabled", {7'd0, irq}, 8'h00);
        bus_read(3'd7, v);
        check("R6 disabled groups latch nothing", v, 8'h40);

        // R6: latency and rising edge in enabled group 0
        lines_in = '0;
        settle();
        bus_write(3'd7, 8'h01);
        lines_in[3] = 1'b1;
        tick();
        tick();
        check("R6 irq not yet after two edges", {7'd0, irq}, 8'h00);
        tick();
        check("R6 irq at third edge", {7'd0, irq}, 8'h01);
        bus_read(3'd7, v);
        check("R7 status group0 pending", v, 8'h01);
        check("R8 irq cleared by read", {7'd0, irq}, 8'h00);
        bus_read(3'd7, v);
        check("R8 status cleared", v, 8'h40);

        // R6: falling edge
        lines_in[3] = 1'b0;
        settle();
        check("R6 falling edge irq", {7'd0, irq}, 8'h01);
        bus_read(3'd7, v);
        check("R6 falling edge status", v, 8'h01);

        // R6: disabled group change ignored
        lines_in[17] = 1'b1;
        settle();
        check("R6 disabled group irq", {7'd0, irq}, 8'h00);
        bus_read(3'd7, v);
        check("R6 disabled group status", v, 8'h40);

        // R5: upper data bits ignored, group 5 enabled
        bus_write(3'd7, 8'hE0);
        lines_in[44] = 1'b1;
        settle();
        bus_read(3'd7, v);
        check("R5 mask bit5 with upper bits", v, 8'h20);
        lines_in[2] = 1'b1;
        settle();
        bus_read(3'd7, v);
        check("R5 group0 now disabled", v, 8'h40);

        // R7: two groups at once
        bus_write(3'd7, 8'h3F);
        lines_in[9]  = 1'b1;
        lines_in[35] = 1'b1;
        settle();
        bus_read(3'd7, v);
        check("R7 two groups reported", v, 8'h12);

        // R4: writes to data offsets ignored
        for (int o = 0; o < 7; o++) bus_write(3'(o), 8'h00);
        bus_read(3'd1, v);
        check("R4 port unchanged by write", v, 8'h02);
        lines_in[27] = 1'b1;
        settle();
        bus_read(3'd7, v);
        check("R4 enable mask kept", v, 8'h08);

        // R9: dropping an enable clears pending bit
        lines_in[30] = 1'b1;
        settle();
        check("R9 irq with latched bit", {7'd0, irq}, 8'h01);
        bus_write(3'd7, 8'h37);
        check("R9 irq after enable drop", {7'd0, irq}, 8'h00);
        bus_read(3'd7, v);
        check("R9 status after drop", v, 8'h40);

        // R8: edge coinciding with status read stays latched
        bus_write(3'd7, 8'h01);
        lines_in[0] = 1'b1;
        settle();
        lines_in[1] = 1'b1;
        tick();
        tick();
        bus_read(3'd7, v);
        check("R8 read returns earlier latch", v, 8'h01);
        check("R8 irq kept by same-cycle edge", {7'd0, irq}, 8'h01);
        bus_read(3'd7, v);
        check("R8 same-cycle edge latched", v, 8'h01);
        bus_read(3'd7, v);
        check("R8 cleared afterwards", v, 8'h40);

        // R1: reset mid-run clears enables
        rst = 1'b1;
        tick();
        rst = 1'b0;
        lines_in[0] = 1'b0;
        settle();
        check("R1 enables cleared by reset", {7'd0, irq}, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule